// File: doc/BRIEF.md
# Bundled-Data Micropipeline Chain Controller

This block sequences a chain of pipeline registers that pass words forward with a four-phase request/acknowledge handshake and bundled data: each channel between two stages carries the data word plus one request wire and one acknowledge wire. Every register alternates between a holding mode and a transparent mode. A two-input Muller C-element per stage decides when to hold. It joins the request arriving from the stage before with the inverted capture-done of the stage after. Each stage issues four control events: capture, capture-done, pass and pass-done.

Data validity is not encoded in the data wires. Each stage holds back its outgoing request with a matched-delay element that stands in for the settling time of the logic between stages. Here that element is a down-counter loaded with a per-stage constant. The chain as a whole behaves like a small FIFO with a four-phase push port and a four-phase pop port. The datapath logic between registers is outside this block, so words pass through unchanged.

Top module: `mp_chain`

## Requirements
- R1: After reset, in_ack and out_req are low, out_data is zero, and every stage is transparent with capture, capture-done and pass-done all low.
- R2: A stage enters holding mode only when its incoming request is high and its successor's capture-done is low. It leaves holding mode only when its incoming request is low and the successor's capture-done is high. In every other case it keeps its mode.
- R3: A stage's capture-done rises the cycle after the stage enters holding mode and falls the cycle after it leaves. The capture-done of stage 0 is in_ack.
- R4: The request a stage forwards rises exactly D+1 cycles after its capture-done rises. D is bits [i*CW +: CW] of STAGE_DELAYS for stage i, so stage 0 uses the least significant field. The forwarded request is low in the cycle after capture-done is seen low.
- R5: While out_req is high, out_data does not change.
- R6: A stage never captures a new word while the word it holds has not yet been captured by its successor (or acknowledged at out_ack, for the last stage).
- R7: Pass-done rises in the same cycle that capture-done falls after a release, stays high while the register is transparent, and clears when the next capture-done rises. Capture-done and pass-done are never high together.
- R8: Both ports follow the four-phase order. in_ack rises only after in_req is high, and out_req returns low only after out_ack has been raised.
- R9: Words leave in the order they entered, with none lost or duplicated, whatever stalls the consumer inserts.
- R10: With out_ack held low, the chain accepts exactly ceil(STAGES/2) words and then withholds in_ack for the next one.
- R11: In an empty chain, out_req is first seen high after the (3*STAGES + sum of all D)-th rising edge, counting the first edge that samples in_req high as edge 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_req | input | 1 | Push request, four-phase |
| in_data | input | WIDTH | Push data, bundled with in_req |
| in_ack | output | 1 | Push acknowledge (stage 0 capture-done) |
| out_req | output | 1 | Pop request, delayed by the last stage's delay element |
| out_data | output | WIDTH | Pop data, held by the last stage |
| out_ack | input | 1 | Pop acknowledge, acts as the last stage's pass command |

## Verification
The bench builds the chain with five stages, 16-bit words and 4-bit delay fields set to 0, 2, 15, 1 and 3 for stages 0 to 4. An odd stage count makes the capacity limit ceil(STAGES/2) = 3 differ from STAGES/2. The set of delays covers both the bypass variant with no counter and a counter that runs from its largest value. The uneven delays also shift the relative timing of neighbouring C-elements, so captures and releases interleave in many different orders during the stalled stream.

// File: rtl/mp_pkg.sv
package mp_pkg;

    // Control events a stage publishes to its neighbours.
    typedef struct packed {
        logic cd;   // capture complete, register holding
        logic pd;   // pass complete, register transparent again
    } stage_evt_t;

    localparam stage_evt_t EVT_IDLE = '{cd: 1'b0, pd: 1'b0};

endpackage

// File: rtl/mp_celem.sv
// Registered Muller C-element: output goes high when every input is high,
// low when every input is low, and otherwise keeps its value.
module mp_celem #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] in_i,
    output logic         nxt_o,
    output logic         q_o
);

    logic state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (&in_i) begin
            state_d = 1'b1;
        end else if (~|in_i) begin
            state_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign nxt_o = state_d;
    assign q_o   = state_q;

endmodule

// File: rtl/mp_delay.sv
// Matched-delay element for the request path. The forwarded request rises
// DELAY+1 cycles after start_i rises and drops the cycle after start_i is low.
module mp_delay #(
    parameter int unsigned CW    = 4,
    parameter int unsigned DELAY = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic fwd_o
);

    localparam logic [CW-1:0] LOAD = CW'(DELAY);

    generate
        if (DELAY == 0) begin : g_bypass
            logic fwd_d, fwd_q;

            always_comb begin
                fwd_d = start_i;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    fwd_q <= 1'b0;
                end else begin
                    fwd_q <= fwd_d;
                end
            end

            assign fwd_o = fwd_q;
        end else begin : g_count
            typedef struct packed {
                logic [CW-1:0] cnt;
                logic          fwd;
            } dly_t;

            dly_t dly_d, dly_q;

            always_comb begin
                dly_d = dly_q;
                if (!start_i) begin
                    dly_d.cnt = LOAD;
                    dly_d.fwd = 1'b0;
                end else if (!dly_q.fwd) begin
                    if (dly_q.cnt == '0) begin
                        dly_d.fwd = 1'b1;
                    end else begin
                        dly_d.cnt = dly_q.cnt - 1'b1;
                    end
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dly_q <= '{cnt: LOAD, fwd: 1'b0};
                end else begin
                    dly_q <= dly_d;
                end
            end

            assign fwd_o = dly_q.fwd;
        end
    endgenerate

endmodule

// File: rtl/mp_stage.sv
// One pipeline register with its capture/pass sequencing.
module mp_stage
    import mp_pkg::*;
#(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned CW    = 4,
    parameter int unsigned DELAY = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             pass_i,
    input  logic [WIDTH-1:0] din_i,
    output logic             cap_o,
    output logic             cd_o,
    output logic             pd_o,
    output logic             fwd_o,
    output logic [WIDTH-1:0] dout_o
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
        stage_evt_t       evt;
    } stage_t;

    stage_t st_d, st_q;
    logic   hold_nxt, hold_q;

    // Join: hold when a request is present and the successor has let go.
    mp_celem #(.N(2)) u_join (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  ({req_i, ~pass_i}),
        .nxt_o (hold_nxt),
        .q_o   (hold_q)
    );

    always_comb begin
        st_d = st_q;
        if (hold_nxt && !hold_q) begin
            st_d.data = din_i;
        end
        st_d.evt.cd = hold_q;
        st_d.evt.pd = !hold_q && (st_q.evt.cd || st_q.evt.pd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{data: '0, evt: EVT_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    mp_delay #(.CW(CW), .DELAY(DELAY)) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (st_q.evt.cd),
        .fwd_o   (fwd_o)
    );

    assign cap_o  = hold_q;
    assign cd_o   = st_q.evt.cd;
    assign pd_o   = st_q.evt.pd;
    assign dout_o = st_q.data;

endmodule

// File: rtl/mp_chain.sv
// Chain of micropipeline stages with a four-phase push and pop port.
module mp_chain #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 4,
    parameter int unsigned CW     = 4,
    parameter logic [STAGES*CW-1:0] STAGE_DELAYS = {4'd1, 4'd3, 4'd0, 4'd2}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_req,
    input  logic [WIDTH-1:0] in_data,
    output logic             in_ack,
    output logic             out_req,
    output logic [WIDTH-1:0] out_data,
    input  logic             out_ack
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] req_vec;
    logic [STAGES-1:0] pass_vec;
    logic [STAGES-1:0] c_vec;
    logic [STAGES-1:0] cd_vec;
    logic [STAGES-1:0] pd_vec;
    logic [STAGES-1:0] fwd_vec;
    logic [WIDTH-1:0]  din_arr  [STAGES];
    logic [WIDTH-1:0]  dout_arr [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            localparam int unsigned D_I = int'(STAGE_DELAYS[i*CW +: CW]);

            if (i == 0) begin : g_head
                assign req_vec[i] = in_req;
                assign din_arr[i] = in_data;
            end else begin : g_body
                assign req_vec[i] = fwd_vec[i-1];
                assign din_arr[i] = dout_arr[i-1];
            end

            if (i == LAST) begin : g_tail
                assign pass_vec[i] = out_ack;
            end else begin : g_mid
                assign pass_vec[i] = cd_vec[i+1];
            end

            mp_stage #(.WIDTH(WIDTH), .CW(CW), .DELAY(D_I)) u_st (
                .clk    (clk),
                .rst_n  (rst_n),
                .req_i  (req_vec[i]),
                .pass_i (pass_vec[i]),
                .din_i  (din_arr[i]),
                .cap_o  (c_vec[i]),
                .cd_o   (cd_vec[i]),
                .pd_o   (pd_vec[i]),
                .fwd_o  (fwd_vec[i]),
                .dout_o (dout_arr[i])
            );
        end
    endgenerate

    assign in_ack   = cd_vec[0];
    assign out_req  = fwd_vec[LAST];
    assign out_data = dout_arr[LAST];

endmodule

// File: rtl/mp_chain_chk.sv
module mp_chain_chk #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 4,
    parameter int unsigned CW     = 4,
    parameter logic [STAGES*CW-1:0] STAGE_DELAYS = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STAGES-1:0] req_vec,
    input logic [STAGES-1:0] pass_vec,
    input logic [STAGES-1:0] c_vec,
    input logic [STAGES-1:0] cd_vec,
    input logic [STAGES-1:0] pd_vec,
    input logic [STAGES-1:0] fwd_vec,
    input logic              out_req,
    input logic [WIDTH-1:0]  out_data,
    input logic              out_ack
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] c_prev;
    logic [STAGES-1:0] occ;
    logic [STAGES-1:0] cap_ev;
    logic [STAGES-1:0] taken_ev;

    always_comb begin
        for (int i = 0; i < STAGES; i++) begin
            cap_ev[i] = c_vec[i] && !c_prev[i];
        end
        for (int i = 0; i < STAGES - 1; i++) begin
            taken_ev[i] = c_vec[i+1] && !c_prev[i+1];
        end
        taken_ev[LAST] = out_ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_prev <= '0;
            occ    <= '0;
        end else begin
            c_prev <= c_vec;
            for (int i = 0; i < STAGES; i++) begin
                if (cap_ev[i]) begin
                    occ[i] <= 1'b1;
                end else if (taken_ev[i]) begin
                    occ[i] <= 1'b0;
                end
            end
        end
    end

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_chk
            localparam int unsigned D_I = int'(STAGE_DELAYS[i*CW +: CW]);
            logic [CW:0] wait_cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    wait_cnt <= '0;
                end else if (!cd_vec[i]) begin
                    wait_cnt <= '0;
                end else if (!fwd_vec[i]) begin
                    wait_cnt <= wait_cnt + 1'b1;
                end
            end

            // R2
            a_r2_join_hold: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(c_vec[i]) |-> $past(req_vec[i]) && !$past(pass_vec[i]));
            // R2
            a_r2_join_release: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(c_vec[i]) |-> !$past(req_vec[i]) && $past(pass_vec[i]));
            // R3
            a_r3_cd_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(cd_vec[i]) |-> $past(c_vec[i]));
            // R4
            a_r4_delay_rise: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(fwd_vec[i]) |-> (wait_cnt == (CW+1)'(D_I + 1)));
            // R4
            a_r4_delay_drop: assert property (@(posedge clk) disable iff (!rst_n)
                !cd_vec[i] |=> !fwd_vec[i]);
            // R6
            a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
                cap_ev[i] |-> !occ[i]);
            // R7
            a_r7_cd_pd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
                !(cd_vec[i] && pd_vec[i]));
            // R7
            a_r7_pd_on_release: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pd_vec[i]) |-> !cd_vec[i] && $past(cd_vec[i]));
        end
    endgenerate

    // R5
    a_r5_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_req && $past(out_req) |-> $stable(out_data));
    // R8
    a_r8_pop_order: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_req) |-> $past(out_ack));

endmodule

bind mp_chain mp_chain_chk #(
    .WIDTH(WIDTH), .STAGES(STAGES), .CW(CW), .STAGE_DELAYS(STAGE_DELAYS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vec  (req_vec),
    .pass_vec (pass_vec),
    .c_vec    (c_vec),
    .cd_vec   (cd_vec),
    .pd_vec   (pd_vec),
    .fwd_vec  (fwd_vec),
    .out_req  (out_req),
    .out_data (out_data),
    .out_ack  (out_ack)
);

// File: tb/sim_mp_chain.sv
module sim_mp_chain;

    localparam int unsigned W  = 16;
    localparam int unsigned S  = 5;
    localparam int unsigned CW = 4;
    localparam int DLY [S] = '{0, 2, 15, 1, 3};
    localparam logic [S*CW-1:0] DLY_PACK = {4'd3, 4'd1, 4'd15, 4'd2, 4'd0};
    localparam int NVEC = 16;
    // {word, consumer stall}
    localparam logic [19:0] TBL [NVEC] = '{
        {16'hA5A5, 4'd0}, {16'h0001, 4'd3}, {16'hFFFF, 4'd0}, {16'h0000, 4'd7},
        {16'h1234, 4'd1}, {16'h8000, 4'd0}, {16'h7FFF, 4'd12}, {16'h5555, 4'd0},
        {16'hAAAA, 4'd2}, {16'hC3C3, 4'd0}, {16'h0F0F, 4'd15}, {16'hBEEF, 4'd0},
        {16'hDEAD, 4'd4}, {16'h0100, 4'd0}, {16'h00FE, 4'd9}, {16'h4242, 4'd1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_req = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_ack;
    logic         out_req;
    logic [W-1:0] out_data;
    logic         out_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mp_chain #(.WIDTH(W), .STAGES(S), .CW(CW), .STAGE_DELAYS(DLY_PACK)) u0 (
        .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_data(in_data),
        .in_ack(in_ack), .out_req(out_req), .out_data(out_data), .out_ack(out_ack)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // status: 0 no ack, 1 acked but ack never returned low, 2 complete
    task automatic push(input logic [W-1:0] w, input int tmo, output int status);
        int n = 0;
        @(negedge clk);
        in_data = w;
        in_req  = 1'b1;
        while (!in_ack && n < tmo) begin
            @(negedge clk);
            n++;
        end
        in_req = 1'b0;
        if (!in_ack) begin
            status = 0;
            return;
        end
        n = 0;
        while (in_ack && n < tmo) begin
            @(negedge clk);
            n++;
        end
        status = in_ack ? 1 : 2;
    endtask

    task automatic pop(input int stall, output logic [W-1:0] got);
        bit held = 1'b1;
        while (!out_req) @(negedge clk);
        got = out_data;
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            if (!out_req || out_data != got) held = 1'b0;
        end
        check(held, "R5/R8 word held until acknowledged", int'(out_data), int'(got));
        out_ack = 1'b1;
        while (out_req) @(negedge clk);
        repeat ($urandom_range(2, 0)) @(negedge clk);
        out_ack = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] got;
        int n;
        int st;
        int acc;
        int exp_lat;

        repeat (3) @(negedge clk);
        // R1: reset state visible at the ports
        check(in_ack == 1'b0, "R1 in_ack at reset", int'(in_ack), 0);
        check(out_req == 1'b0, "R1 out_req at reset", int'(out_req), 0);
        check(out_data == '0, "R1 out_data at reset", int'(out_data), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(in_ack == 1'b0 && out_req == 1'b0, "R1 idle after reset release",
              int'({in_ack, out_req}), 0);

        // R11: latency through an empty chain
        exp_lat = 3 * S;
        for (int i = 0; i < S; i++) exp_lat += DLY[i];
        in_data = 16'h3C5A;
        in_req  = 1'b1;
        n = 0;
        while (!out_req && n < 400) begin
            @(posedge clk);
            n++;
            #1;
            if (in_ack) in_req = 1'b0;
        end
        check(n == exp_lat, "R11 empty-chain latency", n, exp_lat);
        pop(0, got);
        check(got == 16'h3C5A, "R9 latency word value", int'(got), 32'h3C5A);
        repeat (4) @(negedge clk);
        check(in_ack == 1'b0, "R8 in_ack returned low", int'(in_ack), 0);

        // R9: vector table streamed with stalls at the output
        fork
            begin
                for (int i = 0; i < NVEC; i++) begin
                    push(TBL[i][19:4], 100000, st);
                end
            end
            begin
                for (int i = 0; i < NVEC; i++) begin
                    pop(int'(TBL[i][3:0]) + int'($urandom_range(3, 0)), got);
                    check(got == TBL[i][19:4], "R9 word order", int'(got), int'(TBL[i][19:4]));
                end
            end
        join
        repeat (80) @(negedge clk);
        check(out_req == 1'b0, "R9 no extra word after stream", int'(out_req), 0);

        // R10: capacity with the output blocked
        acc = 0;
        for (int k = 0; k < S; k++) begin
            push(16'hE000 + W'(k), 200, st);
            if (st >= 1) acc++;
            if (st != 2) break;
        end
        check(acc == (S + 1) / 2, "R10 words accepted while blocked", acc, (S + 1) / 2);
        check(out_req == 1'b1 && out_data == 16'hE000, "R5 head word presented",
              int'(out_data), 32'hE000);
        for (int k = 0; k < (S + 1) / 2; k++) begin
            pop(1, got);
            check(got == 16'hE000 + W'(k), "R10 drained word order", int'(got),
                  int'(16'hE000 + W'(k)));
        end
        repeat (80) @(negedge clk);
        check(in_ack == 1'b0 && out_req == 1'b0, "R8 both ports idle after drain",
              int'({in_ack, out_req}), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule